// File: doc/BRIEF.md
# Page Buffer Operation Sequencer

The sequencer carries out the self-timed part of four page-level flash operations after a command front end has decoded them. A one-cycle start pulse delivers an operation code, a buffer select and a 13-bit page number. The block then steps through its internal phases without further host involvement. Those phases move bytes between a byte-wide flash array port and one of two 528-byte page buffers, compare them, erase a page or program it. The array and both buffers sit outside the block and are read combinationally, one byte per clock.

While an operation runs, the ready bit of the status byte is low. When a compare finishes, its outcome is latched into the status byte. Programming always erases the target page to all ones before any byte is written. The automatic rewrite chains a page-to-buffer copy with the erase and program phases on the same page.

Top module: `pgbuf_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `stat_o` reads 0x80 (bit 7 = ready, bit 6 = 0, other bits 0) until a compare sets bit 6. No array write, array erase or buffer write strobe is active while idle.
- R2: Operation code 0 (transfer) copies page byte i into byte i of the selected buffer (buffer select 0 = first buffer, 1 = second) for i = 0..527. The other buffer is not written.
- R3: Operation code 2 (program) holds the erase strobe for the page for exactly ERASE_CYC cycles. It then writes byte i of the selected buffer into page byte i. Afterwards the page equals the buffer, even where the old contents had cleared bits.
- R4: Operation code 1 (compare) checks all 528 bytes of the page against the selected buffer. It sets status bit 6 to 0 when all bytes match and to 1 when any byte differs, including the first or the last byte.
- R5: Status bit 6 keeps its value through other operations and changes only when a compare completes.
- R6: Status bit 7 is 0 from the cycle after the start pulse until the operation ends. The busy time is 529 cycles for transfer and compare, ERASE_CYC+PROG_CYC+1 for program, and 528+ERASE_CYC+PROG_CYC+1 for rewrite.
- R7: A start pulse that arrives while status bit 7 is 0 has no effect. The running operation keeps its page, buffer, code and duration, and no other page is touched.
- R8: Operation code 3 (rewrite) first copies the page into the selected buffer, then erases the same page and programs it back from that buffer. The page ends with its original contents and the buffer ends equal to the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | Operation code: 0 transfer, 1 compare, 2 program, 3 rewrite |
| buf_sel_i | input | 1 | Buffer choice: 0 first, 1 second |
| page_i | input | 13 | Target page number |
| arr_page_o | output | 13 | Page addressed in the array |
| arr_col_o | output | 10 | Byte index within the page |
| arr_rd_data_i | input | 8 | Array read data for the addressed byte |
| arr_wr_en_o | output | 1 | Array byte program strobe |
| arr_wr_data_o | output | 8 | Byte to program |
| arr_erase_o | output | 1 | Erase-page strobe (page set to all ones) |
| buf_sel_o | output | 1 | Buffer being accessed |
| buf_addr_o | output | 10 | Byte index within the buffer |
| buf_rd_data_i | input | 8 | Buffer read data |
| buf_wr_en_o | output | 1 | Buffer byte write strobe |
| buf_wr_data_o | output | 8 | Byte written into the buffer |
| stat_o | output | 8 | Status byte: bit 7 ready, bit 6 compare mismatch |

## Verification
The start pulse is sampled on one edge. Busy is visible at the next falling edge and stays low-ready for the phase lengths listed in R6. The bench counts those falling-edge samples and checks the count exactly. Buffer, page and status results are compared only after the ready bit has returned, so every phase and the final one-cycle completion state have elapsed. Erase cycles are counted at the same falling edges, inside the busy window.

// File: rtl/pgbuf_pkg.sv
// Shared types for the page buffer sequencer: phase states and operation codes.
package pgbuf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_XFER  = 3'd1,
        ST_CMP   = 3'd2,
        ST_ERASE = 3'd3,
        ST_PROG  = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_XFER = 2'd0,
        OP_CMP  = 2'd1,
        OP_PROG = 2'd2,
        OP_REWR = 2'd3
    } seq_op_e;
endpackage

// File: rtl/pgbuf_ctrl.sv
// Phase controller: latches the command in idle and walks the phases the
// operation needs (copy, compare, erase, program, done). It owns the byte
// index and the erase/program down-counter.
// Assumes PROG_CYC >= PAGE_BYTES so every byte is written within the program phase.
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int PAGE_BYTES = 528,
    parameter int PAGE_W     = 13,
    parameter int ERASE_CYC  = 1000,
    parameter int PROG_CYC   = 2000,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
    localparam int CNT_W     = $clog2(MAX_CYC) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              buf_sel_i,
    input  logic [PAGE_W-1:0] page_i,
    output seq_state_e        state_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              last_o,
    output logic              wr_act_o,
    output logic              buf_q_o,
    output logic [PAGE_W-1:0] page_q_o
);
    seq_state_e        state_q;
    seq_op_e           op_q;
    logic              buf_q;
    logic [PAGE_W-1:0] page_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_act_q;
    logic              last;

    assign last = (idx_q == IDX_W'(PAGE_BYTES - 1));

    // Phase sequencing, command latch, byte index and phase timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_XFER;
            buf_q    <= 1'b0;
            page_q   <= '0;
            idx_q    <= '0;
            cnt_q    <= '0;
            wr_act_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q   <= seq_op_e'(op_i);
                        buf_q  <= buf_sel_i;
                        page_q <= page_i;
                        idx_q  <= '0;
                        cnt_q  <= CNT_W'(ERASE_CYC - 1);
                        case (seq_op_e'(op_i))
                            OP_CMP:  state_q <= ST_CMP;
                            OP_PROG: state_q <= ST_ERASE;
                            default: state_q <= ST_XFER;
                        endcase
                    end
                end
                ST_XFER: begin
                    if (last) begin
                        idx_q   <= '0;
                        state_q <= (op_q == OP_REWR) ? ST_ERASE : ST_DONE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_CMP: begin
                    if (last) state_q <= ST_DONE;
                    else      idx_q   <= idx_q + IDX_W'(1);
                end
                ST_ERASE: begin
                    if (cnt_q == '0) begin
                        state_q  <= ST_PROG;
                        cnt_q    <= CNT_W'(PROG_CYC - 1);
                        idx_q    <= '0;
                        wr_act_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_PROG: begin
                    if (wr_act_q) begin
                        if (last) wr_act_q <= 1'b0;
                        else      idx_q    <= idx_q + IDX_W'(1);
                    end
                    if (cnt_q == '0) begin
                        state_q  <= ST_DONE;
                        wr_act_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o  = state_q;
    assign idx_o    = idx_q;
    assign last_o   = last;
    assign wr_act_o = wr_act_q;
    assign buf_q_o  = buf_q;
    assign page_q_o = page_q;

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> ($stable(page_q) && $stable(buf_q) && $stable(op_q))); // R7

    AST_ERASE_BEFORE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) != ST_PROG) |-> ($past(state_q) == ST_ERASE)); // R3

    AST_CMP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMP && $past(state_q) != ST_CMP) |-> ($past(state_q) == ST_IDLE)); // R4

    AST_IDX_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < IDX_W'(PAGE_BYTES)); // R2
endmodule

// File: rtl/pgbuf_cmp.sv
// Compare accumulator: ORs byte differences over a compare phase and
// latches the result into the mismatch flag on the last byte.
// Assumes clr_i is asserted between operations (idle) to restart accumulation.
module pgbuf_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic last_i,
    input  logic diff_i,
    output logic mismatch_o
);
    logic acc_q;
    logic flag_q;

    // Running difference accumulator and the held compare result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (clr_i)     acc_q <= 1'b0;
            else if (en_i) acc_q <= acc_q | diff_i;
            if (en_i && last_i) flag_q <= acc_q | diff_i;
        end
    end

    assign mismatch_o = flag_q;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && last_i) |=> $stable(flag_q)); // R5
endmodule

// File: rtl/pgbuf_seq.sv
// Page buffer operation sequencer top: joins the phase controller and the
// compare accumulator and routes bytes between array and buffer ports.
// Assumes array and buffer reads are combinational for the presented address.
module pgbuf_seq
    import pgbuf_pkg::*;
#(
    parameter int PAGE_BYTES = 528,
    parameter int PAGE_W     = 13,
    parameter int DATA_W     = 8,
    parameter int ERASE_CYC  = 1000,
    parameter int PROG_CYC   = 2000,
    localparam int COL_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              buf_sel_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic [PAGE_W-1:0] arr_page_o,
    output logic [COL_W-1:0]  arr_col_o,
    input  logic [DATA_W-1:0] arr_rd_data_i,
    output logic              arr_wr_en_o,
    output logic [DATA_W-1:0] arr_wr_data_o,
    output logic              arr_erase_o,
    output logic              buf_sel_o,
    output logic [COL_W-1:0]  buf_addr_o,
    input  logic [DATA_W-1:0] buf_rd_data_i,
    output logic              buf_wr_en_o,
    output logic [DATA_W-1:0] buf_wr_data_o,
    output logic [7:0]        stat_o
);
    seq_state_e        state;
    logic [COL_W-1:0]  idx;
    logic              last;
    logic              wr_act;
    logic              mismatch;

    pgbuf_ctrl #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_W     (PAGE_W),
        .ERASE_CYC  (ERASE_CYC),
        .PROG_CYC   (PROG_CYC)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .buf_sel_i (buf_sel_i),
        .page_i    (page_i),
        .state_o   (state),
        .idx_o     (idx),
        .last_o    (last),
        .wr_act_o  (wr_act),
        .buf_q_o   (buf_sel_o),
        .page_q_o  (arr_page_o)
    );

    pgbuf_cmp cmp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (state == ST_IDLE),
        .en_i       (state == ST_CMP),
        .last_i     (last),
        .diff_i     (arr_rd_data_i != buf_rd_data_i),
        .mismatch_o (mismatch)
    );

    // Byte routing and strobes for the current phase.
    always_comb begin
        arr_col_o     = idx;
        buf_addr_o    = idx;
        buf_wr_en_o   = (state == ST_XFER);
        buf_wr_data_o = arr_rd_data_i;
        arr_wr_en_o   = (state == ST_PROG) && wr_act;
        arr_wr_data_o = buf_rd_data_i;
        arr_erase_o   = (state == ST_ERASE);
        stat_o        = {(state == ST_IDLE), mismatch, 6'b0};
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[7] |-> !(arr_wr_en_o || buf_wr_en_o || arr_erase_o)); // R1
endmodule

// File: tb/pgbuf_seq_tb_top.sv
// Directed bench for the page buffer sequencer with a small flash and buffer model.
module pgbuf_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 528;
    localparam int EC   = 20;
    localparam int PC   = 540;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic        buf_sel_i = 1'b0;
    logic [12:0] page_i = '0;
    logic [12:0] arr_page_o;
    logic [9:0]  arr_col_o;
    logic [7:0]  arr_rd_data_i;
    logic        arr_wr_en_o;
    logic [7:0]  arr_wr_data_o;
    logic        arr_erase_o;
    logic        buf_sel_o;
    logic [9:0]  buf_addr_o;
    logic [7:0]  buf_rd_data_i;
    logic        buf_wr_en_o;
    logic [7:0]  buf_wr_data_o;
    logic [7:0]  stat_o;

    logic [7:0] fmem [4][NB];
    logic [7:0] bufa [NB];
    logic [7:0] bufb [NB];

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgbuf_seq #(.ERASE_CYC(EC), .PROG_CYC(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .buf_sel_i(buf_sel_i), .page_i(page_i),
        .arr_page_o(arr_page_o), .arr_col_o(arr_col_o), .arr_rd_data_i(arr_rd_data_i),
        .arr_wr_en_o(arr_wr_en_o), .arr_wr_data_o(arr_wr_data_o), .arr_erase_o(arr_erase_o),
        .buf_sel_o(buf_sel_o), .buf_addr_o(buf_addr_o), .buf_rd_data_i(buf_rd_data_i),
        .buf_wr_en_o(buf_wr_en_o), .buf_wr_data_o(buf_wr_data_o), .stat_o(stat_o)
    );

    assign arr_rd_data_i = fmem[arr_page_o[1:0]][arr_col_o];
    assign buf_rd_data_i = buf_sel_o ? bufb[buf_addr_o] : bufa[buf_addr_o];

    // Flash model: erase sets all ones, program can only clear bits.
    always @(posedge clk) begin
        if (arr_erase_o)
            for (int i = 0; i < NB; i++) fmem[arr_page_o[1:0]][i] <= 8'hFF;
        if (arr_wr_en_o)
            fmem[arr_page_o[1:0]][arr_col_o] <= fmem[arr_page_o[1:0]][arr_col_o] & arr_wr_data_o;
        if (buf_wr_en_o) begin
            if (buf_sel_o) bufb[buf_addr_o] <= buf_wr_data_o;
            else           bufa[buf_addr_o] <= buf_wr_data_o;
        end
    end

    function automatic logic [7:0] pat(int p, int i);
        int v;
        v = p * 37 + i * 11 + 5;
        return v[7:0];
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compares a page against expected bytes; one check, first mismatch reported.
    task automatic chk_page(string req, int p, logic [7:0] exp [NB]);
        int bad_i = -1;
        for (int i = 0; i < NB; i++)
            if (bad_i < 0 && fmem[p][i] !== exp[i]) bad_i = i;
        n_chk++;
        if (bad_i >= 0) begin
            n_bad++;
            $display("FAIL %s: page %0d byte %0d actual %0h expected %0h",
                     req, p, bad_i, fmem[p][bad_i], exp[bad_i]);
        end
    endtask

    task automatic chk_buf(string req, bit sel, logic [7:0] exp [NB]);
        int bad_i = -1;
        logic [7:0] v;
        for (int i = 0; i < NB; i++) begin
            v = sel ? bufb[i] : bufa[i];
            if (bad_i < 0 && v !== exp[i]) bad_i = i;
        end
        n_chk++;
        if (bad_i >= 0) begin
            n_bad++;
            v = sel ? bufb[bad_i] : bufa[bad_i];
            $display("FAIL %s: buffer %0d byte %0d actual %0h expected %0h",
                     req, sel, bad_i, v, exp[bad_i]);
        end
    endtask

    // Issues one operation and measures busy cycles and erase cycles.
    task automatic run_op(input logic [1:0] op, input bit sel, input int pg,
                          input bit inject, output int dur, output int ers);
        @(negedge clk);
        start_i = 1'b1; op_i = op; buf_sel_i = sel; page_i = 13'(pg);
        @(negedge clk);
        start_i = 1'b0;
        dur = 0; ers = 0;
        while (!stat_o[7] && dur < 5000) begin
            dur++;
            if (arr_erase_o) ers++;
            if (inject && dur == 5) begin
                start_i = 1'b1; op_i = 2'd2; buf_sel_i = 1'b0; page_i = 13'd2;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status after reset", int'(stat_o), 8'h80);
        chk("R1 strobes idle", int'({arr_wr_en_o, buf_wr_en_o, arr_erase_o}), 0);
    endtask

    task automatic t_transfer;
        int d, e;
        logic [7:0] ex [NB];
        logic [7:0] eb [NB];
        for (int i = 0; i < NB; i++) begin ex[i] = pat(1, i); eb[i] = 8'h5A; end
        run_op(2'd0, 1'b0, 1, 1'b0, d, e);
        chk("R6 transfer busy cycles", d, NB + 1);
        chk_buf("R2 first buffer holds page 1", 1'b0, ex);
        chk_buf("R2 second buffer untouched", 1'b1, eb);
        chk("R1 ready after transfer", int'(stat_o), 8'h80);
    endtask

    task automatic t_compare;
        int d, e;
        logic [7:0] ex [NB];
        run_op(2'd1, 1'b0, 1, 1'b0, d, e);
        chk("R6 compare busy cycles", d, NB + 1);
        chk("R4 compare match bit6", int'(stat_o[6]), 0);
        bufa[NB-1] = bufa[NB-1] ^ 8'h01;
        run_op(2'd1, 1'b0, 1, 1'b0, d, e);
        chk("R4 mismatch on last byte", int'(stat_o[6]), 1);
        for (int i = 0; i < NB; i++) ex[i] = pat(2, i);
        run_op(2'd0, 1'b1, 2, 1'b0, d, e);
        chk_buf("R2 second buffer holds page 2", 1'b1, ex);
        chk("R5 bit6 held across transfer", int'(stat_o[6]), 1);
        bufa[NB-1] = pat(1, NB-1);
        bufa[0] = bufa[0] ^ 8'h80;
        run_op(2'd1, 1'b0, 1, 1'b0, d, e);
        chk("R4 mismatch on first byte", int'(stat_o[6]), 1);
        bufa[0] = pat(1, 0);
        run_op(2'd1, 1'b0, 1, 1'b0, d, e);
        chk("R5 bit6 cleared by next compare", int'(stat_o[6]), 0);
    endtask

    task automatic t_program;
        int d, e;
        logic [7:0] ex [NB];
        logic [7:0] e2 [NB];
        for (int i = 0; i < NB; i++) begin
            bufb[i] = ~pat(3, i) ^ 8'h3C;
            ex[i] = bufb[i];
            e2[i] = pat(2, i);
        end
        run_op(2'd2, 1'b1, 3, 1'b0, d, e);
        chk("R6 program busy cycles", d, EC + PC + 1);
        chk("R3 erase cycles", e, EC);
        chk_page("R3 page 3 equals buffer", 3, ex);
        chk_page("R3 page 2 untouched", 2, e2);
    endtask

    task automatic t_rewrite;
        int d, e;
        logic [7:0] ex [NB];
        for (int i = 0; i < NB; i++) begin bufa[i] = 8'h00; ex[i] = pat(0, i); end
        run_op(2'd3, 1'b0, 0, 1'b0, d, e);
        chk("R6 rewrite busy cycles", d, NB + EC + PC + 1);
        chk("R8 rewrite erase cycles", e, EC);
        chk_buf("R8 buffer equals page", 1'b0, ex);
        chk_page("R8 page keeps contents", 0, ex);
    endtask

    task automatic t_busy_start;
        int d, e;
        logic [7:0] ex [NB];
        logic [7:0] e2 [NB];
        for (int i = 0; i < NB; i++) begin ex[i] = pat(0, i); e2[i] = pat(2, i); end
        run_op(2'd0, 1'b1, 0, 1'b1, d, e);
        chk("R7 duration unchanged by busy start", d, NB + 1);
        chk("R7 no erase from busy start", e, 0);
        chk_buf("R7 running transfer completed", 1'b1, ex);
        chk_page("R7 page 2 untouched", 2, e2);
        repeat (3) @(negedge clk);
        chk("R7 stays idle after busy start", int'(stat_o[7]), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < NB; i++) fmem[p][i] = pat(p, i);
        for (int i = 0; i < NB; i++) begin bufa[i] = 8'hA5; bufb[i] = 8'h5A; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_transfer();
        t_compare();
        t_program();
        t_rewrite();
        t_busy_start();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule